// File: doc/BRIEF.md
# Programmable IR Carrier Generator

This block makes the square-wave carrier that an infrared transmitter modulates. It runs directly from the oscillator-rate clock. The high time and the low time are set independently. Each time is an 8-bit count, and software writes it as separate 4-bit nibbles. A high phase lasts the high count plus one clock and a low phase lasts the low count plus one clock, so the carrier period is the high count plus the low count plus two clocks. With a 4 MHz clock and a period of 105 clocks the carrier is about 38.1 kHz.

Nibble writes land in shadow registers. The timer copies the shadow values into its working copies only when a new high phase begins, so a carrier period never mixes an old count with a new one. A one-bit output latch gates the carrier onto the pin. While the latch is 0 the pin is low, the phase timer is held at the start of a high phase, and the working copies keep following the shadow registers. When the latch becomes 1, the pin goes high in that same cycle and a full high phase begins.

Top module: `ir_carrier_gen`

## Requirements
- R1: Each high phase holds `pin_out` at 1 for (H+1) consecutive clocks, where H is the working high count.
- R2: Each low phase holds `pin_out` at 0 for (L+1) consecutive clocks, where L is the working low count.
- R3: While `latch` stays 1 the carrier repeats with a period of H+L+2 clocks, starting with the high phase.
- R4: The count registers are assembled from nibbles. Strobe bit 1 of `hi_wr` or `lo_wr` loads `wr_data` into bits 7:4 of the high or low count, and strobe bit 0 loads bits 3:0. A write to one nibble leaves the other nibble and the other count unchanged.
- R5: A count written while the carrier runs does not alter the current period. The new count first applies to the high phase that follows the next low phase.
- R6: While `latch` is 0, `pin_out` is 0, whatever the count writes.
- R7: In the first cycle in which `latch` is 1 after being 0, `pin_out` is 1, and a full high phase of H+1 clocks begins.
- R8: When `latch` goes from 1 to 0, `pin_out` is 0 in that same cycle and the phase timer returns to the start of a high phase. When the latch is next set, the high phase runs its full length.
- R9: After reset both counts are 0 and `pin_out` is 0. With both counts at 0 and `latch` at 1, the pin alternates 1, 0 on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_wr | input | 2 | Nibble write strobes for the high count (bit 1 = upper nibble) |
| lo_wr | input | 2 | Nibble write strobes for the low count (bit 1 = upper nibble) |
| wr_data | input | 4 | Nibble value written by any active strobe |
| latch | input | 1 | Output latch bit; 1 sends the carrier to the pin |
| pin_out | output | 1 | Gated carrier for the high-current pin |

## Verification
The assertions check on every cycle that:
- the phase counter never passes the bound of its phase;
- a phase cannot end before its count is reached;
- the working counts change only at a high-phase boundary or while the carrier is idle;
- the pin is low whenever the latch is 0;
- a rising latch starts the carrier high.

The assertions do not check the nibble layout, the exact run lengths or the moment a buffered write takes effect. The bench covers these with a behavioural model and with measured high and low run lengths around mid-period writes and latch toggles.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

   // Replace nibble number idx of a value with nib.
   function automatic logic [63:0] put_nibble(input logic [63:0] val,
                                              input logic [63:0] nib,
                                              input int          idx,
                                              input int          nib_w);
      logic [63:0] mask;
      mask = ((64'd1 << nib_w) - 64'd1) << (idx * nib_w);
      return (val & ~mask) | ((nib << (idx * nib_w)) & mask);
   endfunction

endpackage

// File: rtl/ir_count_shadow.sv
module ir_count_shadow #(
   parameter int NIB_W   = 4,
   parameter int NIBBLES = 2,
   localparam int CNT_W  = NIB_W * NIBBLES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NIBBLES-1:0] wr,
   input  logic [NIB_W-1:0]   wr_data,
   output logic [CNT_W-1:0]   value
);

   generate
      for (genvar k = 0; k < NIBBLES; k++) begin : g_nib
         logic [NIB_W-1:0] nib_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               nib_q <= '0;
            end else if (wr[k]) begin
               nib_q <= wr_data;
            end
         end
         assign value[k*NIB_W +: NIB_W] = nib_q;
      end
   endgenerate

endmodule

// File: rtl/ir_phase_timer.sv
module ir_phase_timer
   import ir_carrier_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] hi_next,
   input  logic [CNT_W-1:0] lo_next,
   output phase_e           phase,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] hi_act,
   output logic [CNT_W-1:0] lo_act
);

   localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

   logic hi_done;
   logic lo_done;

   assign hi_done = (cnt == hi_act);
   assign lo_done = (cnt == lo_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_HIGH;
         cnt    <= '0;
         hi_act <= '0;
         lo_act <= '0;
      end else if (!enable) begin
         phase  <= PH_HIGH;
         cnt    <= '0;
         hi_act <= hi_next;
         lo_act <= lo_next;
      end else if (phase == PH_HIGH) begin
         if (hi_done) begin
            phase <= PH_LOW;
            cnt   <= '0;
         end else begin
            cnt <= cnt + STEP;
         end
      end else begin
         if (lo_done) begin
            phase  <= PH_HIGH;
            cnt    <= '0;
            hi_act <= hi_next;
            lo_act <= lo_next;
         end else begin
            cnt <= cnt + STEP;
         end
      end
   end

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
   import ir_carrier_pkg::*;
#(
   parameter int NIB_W   = 4,
   parameter int NIBBLES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NIBBLES-1:0] hi_wr,
   input  logic [NIBBLES-1:0] lo_wr,
   input  logic [NIB_W-1:0]   wr_data,
   input  logic               latch,
   output logic               pin_out
);

   localparam int CNT_W = NIB_W * NIBBLES;

   generate
      if (NIB_W < 1 || NIBBLES < 1) begin : g_bad_shape
         $fatal(1, "ir_carrier_gen: NIB_W and NIBBLES must be at least 1");
      end
      if (CNT_W > 32) begin : g_bad_width
         $fatal(1, "ir_carrier_gen: count width above 32 bits");
      end
   endgenerate

   logic [CNT_W-1:0] hi_shadow;
   logic [CNT_W-1:0] lo_shadow;
   logic [CNT_W-1:0] hi_act;
   logic [CNT_W-1:0] lo_act;
   logic [CNT_W-1:0] cnt;
   phase_e           phase;
   logic             phase_high;

   ir_count_shadow #(.NIB_W(NIB_W), .NIBBLES(NIBBLES)) u_hi_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (hi_wr),
      .wr_data (wr_data),
      .value   (hi_shadow)
   );

   ir_count_shadow #(.NIB_W(NIB_W), .NIBBLES(NIBBLES)) u_lo_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (lo_wr),
      .wr_data (wr_data),
      .value   (lo_shadow)
   );

   ir_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (latch),
      .hi_next (hi_shadow),
      .lo_next (lo_shadow),
      .phase   (phase),
      .cnt     (cnt),
      .hi_act  (hi_act),
      .lo_act  (lo_act)
   );

   assign phase_high = (phase == PH_HIGH);

   // Gate the carrier combinationally so a cleared latch drops the pin at once.
   assign pin_out = latch & phase_high;

endmodule

// File: rtl/ir_carrier_gen_chk.sv
module ir_carrier_gen_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             latch,
   input logic             pin_out,
   input logic             phase_high,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] hi_act,
   input logic [CNT_W-1:0] lo_act
);

   // R1: a high phase cannot end before its count is reached
   assert_high_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (latch && phase_high && cnt != hi_act) |=> phase_high);

   // R2: a low phase cannot end before its count is reached
   assert_low_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (latch && !phase_high && cnt != lo_act) |=> !phase_high);

   // R3: the counter stays within the bound of its phase
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_high ? (cnt <= hi_act) : (cnt <= lo_act)));

   // R5: working counts change only at a high-phase boundary or while idle
   assert_buffered_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (latch && !(!phase_high && cnt == lo_act)) |=> ($stable(hi_act) && $stable(lo_act)));

   // R6: a cleared latch keeps the pin low
   assert_gate_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !latch |-> !pin_out);

   // R7: a rising latch starts with the pin high
   assert_start_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch) |-> pin_out);

   // R8: an idle cycle returns the timer to the start of a high phase
   assert_idle_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !latch |=> (phase_high && cnt == '0));

endmodule

bind ir_carrier_gen ir_carrier_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .latch      (latch),
   .pin_out    (pin_out),
   .phase_high (phase_high),
   .cnt        (cnt),
   .hi_act     (hi_act),
   .lo_act     (lo_act)
);

// File: tb/ir_carrier_gen_test.sv
module ir_carrier_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] hi_wr = 2'b00;
   logic [1:0] lo_wr = 2'b00;
   logic [3:0] wr_data = 4'h0;
   logic       latch = 1'b0;
   logic       pin_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit pin_s = 1'b0;

   // behavioural model state
   int m_sh_hi = 0, m_sh_lo = 0;
   int m_hi = 0, m_lo = 0;
   int m_left = 1;
   bit m_high = 1'b1;

   ir_carrier_gen uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .hi_wr   (hi_wr),
      .lo_wr   (lo_wr),
      .wr_data (wr_data),
      .latch   (latch),
      .pin_out (pin_out)
   );

   always #10 clk = ~clk;

   function automatic int ins(input int v, input logic [1:0] w, input int d);
      int r = v;
      if (w[1]) r = (r & 'h0F) | (d << 4);
      if (w[0]) r = (r & 'hF0) | d;
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sh_hi = 0; m_sh_lo = 0; m_hi = 0; m_lo = 0;
         m_left = 1; m_high = 1'b1;
      end else begin
         if (!latch) begin
            m_high = 1'b1;
            m_hi = m_sh_hi;
            m_lo = m_sh_lo;
            m_left = m_sh_hi + 1;
         end else begin
            m_left = m_left - 1;
            if (m_left == 0) begin
               if (m_high) begin
                  m_high = 1'b0;
                  m_left = m_lo + 1;
               end else begin
                  m_high = 1'b1;
                  m_hi = m_sh_hi;
                  m_lo = m_sh_lo;
                  m_left = m_hi + 1;
               end
            end
         end
         m_sh_hi = ins(m_sh_hi, hi_wr, int'(wr_data));
         m_sh_lo = ins(m_sh_lo, lo_wr, int'(wr_data));
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input bit l, input logic [1:0] hw, input logic [1:0] lw,
                       input logic [3:0] d);
      @(negedge clk);
      latch = l; hi_wr = hw; lo_wr = lw; wr_data = d;
      #1;
      pin_s = pin_out;
      chk(pin_out === (l & m_high), "R3 cycle model", int'(pin_out), int'(l & m_high));
   endtask

   task automatic run_of(input bit lvl, output int n);
      n = 0;
      while (pin_s == lvl && n < 1000) begin
         n++;
         step(latch, 2'b00, 2'b00, 4'h0);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n, hrun, lrun;
      // R9: reset state
      repeat (3) @(negedge clk);
      #1;
      chk(pin_out === 1'b0, "R9 reset pin", int'(pin_out), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: zero counts toggle every clock
      step(1, 2'b00, 2'b00, 4'h0); chk(pin_s == 1'b1, "R9 toggle c1", pin_s, 1);
      step(1, 2'b00, 2'b00, 4'h0); chk(pin_s == 1'b0, "R9 toggle c2", pin_s, 0);
      step(1, 2'b00, 2'b00, 4'h0); chk(pin_s == 1'b1, "R9 toggle c3", pin_s, 1);
      step(1, 2'b00, 2'b00, 4'h0); chk(pin_s == 1'b0, "R9 toggle c4", pin_s, 0);

      // R6 / R4: program high = 0x33, low = 0x34 nibble by nibble with latch 0
      step(0, 2'b10, 2'b00, 4'h3); chk(pin_s == 1'b0, "R6 idle low a", pin_s, 0);
      step(0, 2'b01, 2'b00, 4'h3); chk(pin_s == 1'b0, "R6 idle low b", pin_s, 0);
      step(0, 2'b00, 2'b10, 4'h3); chk(pin_s == 1'b0, "R6 idle low c", pin_s, 0);
      step(0, 2'b00, 2'b01, 4'h4); chk(pin_s == 1'b0, "R6 idle low d", pin_s, 0);
      step(0, 2'b00, 2'b00, 4'h0);

      // R7: rising latch starts high; R5: write high low nibble to 2 mid-phase
      step(1, 2'b00, 2'b00, 4'h0); chk(pin_s == 1'b1, "R7 start high", pin_s, 1);
      step(1, 2'b01, 2'b00, 4'h2);
      run_of(1, n); hrun = n + 1;
      chk(hrun == 52, "R1 high run 0x33", hrun, 52);
      run_of(0, lrun);
      chk(lrun == 53, "R2 low run 0x34", lrun, 53);
      chk(hrun + lrun == 105, "R3 period", hrun + lrun, 105);
      run_of(1, n);
      chk(n == 51, "R5 new high count applied", n, 51);
      run_of(0, n);
      chk(n == 53, "R2 low run repeat", n, 53);

      // R8: drop the latch mid-high, then restart with a full high phase
      step(1, 2'b00, 2'b00, 4'h0);
      step(1, 2'b00, 2'b00, 4'h0);
      step(0, 2'b00, 2'b00, 4'h0); chk(pin_s == 1'b0, "R8 immediate low", pin_s, 0);
      step(1, 2'b00, 2'b00, 4'h0); chk(pin_s == 1'b1, "R7 restart high", pin_s, 1);
      run_of(1, n);
      chk(n == 51, "R8 full high after restart", n, 51);

      // R4 / R5: clear the upper nibble of the low count during a low phase
      step(1, 2'b00, 2'b10, 4'h0);
      run_of(0, n);
      chk(n + 1 == 53, "R5 current low kept", n + 1, 53);
      run_of(1, n);
      chk(n == 51, "R4 high count untouched", n, 51);
      run_of(0, n);
      chk(n == 5, "R4 upper nibble only", n, 5);

      step(0, 2'b00, 2'b00, 4'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule